// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits beside an asynchronous-strobe DRAM interface, either as a bus monitor or as the control front end of a device model. It samples the four active-low strobes (row strobe, column strobe, write enable, output enable) and the multiplexed address bus on a fast system clock, then names each memory cycle as it finishes. It latches the row and column that each cycle used. It keeps its own refresh counter for the refresh cycles that carry no external row, and it tracks a test-mode flag. It also reports whether the data pins should be driven by the memory at any moment.

The classes it reports are a read, an early write, a read-write (late write), a page-mode continuation, a row-only refresh, a column-before-row refresh, a hidden refresh and a test-mode entry. Each cycle produces one pulse on `cyc_valid` with a 3-bit code. A protocol-error pulse marks strobe orderings that cannot be resolved in one sample.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After a synchronous reset, `cyc_valid`, `proto_err`, `test_mode` and `dq_out_en` are 0, `row_q` and `col_q` are 0, and the refresh counter is 0.
- R2: A row-strobe fall with the column strobe high latches `addr` into `row_q`. The first column-strobe fall in that row latches `addr` into `col_q`. If write enable is high at that fall and stays high, the cycle is reported with code 0 (read).
- R3: If write enable is low in the sample where the column strobe falls, including when both fall in the same sample, the cycle is reported with code 1 (early write), and `dq_out_en` stays 0 for the whole column cycle.
- R4: If write enable falls while the column strobe is low after a code-0 column latch, the report becomes code 2 (read-write).
- R5: Every column-strobe fall after the first within one row-strobe low period latches a new column and is reported with code 3 (page continuation).
- R6: A row-strobe low period with no column-strobe activity is reported with code 4 at the row-strobe rise, uses the row from `addr`, and clears `test_mode`.
- R7: A row-strobe fall while the column strobe is already low and write enable is high is reported with code 5 at the row-strobe rise. It places the refresh counter value in `row_q`, advances the counter by one modulo 2^AW, and clears `test_mode`.
- R8: The same ordering with write enable low is reported with code 7 and sets `test_mode`. It also uses and advances the counter. Only codes 4 and 5 clear `test_mode`; access cycles leave it unchanged.
- R9: If the column strobe stays low from an access through a row-strobe rise and a new fall, the cycle is reported with code 6. It uses and advances the counter, and `dq_out_en` keeps its value until the column strobe rises.
- R10: `dq_out_en` is 1 only while the column strobe and output enable are both low and a non-early-write column has been latched since the column strobe last fell. It drops when the column strobe rises, whatever output enable does.
- R11: `proto_err` pulses for one cycle in two cases. The first is when the row and column strobes fall in the same sample. The second is when write enable changes in the sample where the row strobe falls with the column strobe already low.
- R12: Each access is reported exactly once, at the first rising edge of the column strobe or the row strobe after its column was latched. Row-type reports occur only on a row-strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| cyc_valid | output | 1 | One-cycle pulse marking a finished cycle |
| cyc_code | output | 3 | Cycle class code (0..7 as in R2-R9) |
| row_q | output | AW | Row used by the latest row-strobe fall |
| col_q | output | AW | Column of the latest access |
| test_mode | output | 1 | Test-mode flag |
| dq_out_en | output | 1 | Memory expected to drive the data pins |
| proto_err | output | 1 | One-cycle protocol violation pulse |

## Verification
The hardest case to reach is the hidden refresh. The column strobe must stay low across a complete row-strobe rise and fall after a read, so the access report moves to the row-strobe rise while the data pins stay driven. The bench builds this sequence step by step and checks the drive state at each step. The refresh counter wrap needs more than 2^AW refresh cycles, so the bench runs a full sweep of column-before-row cycles that passes the wrap point. It also sweeps every write-enable placement against both output-enable levels.

// File: rtl/dsd_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM strobe cycle decoder.
// Assumes: codes are consumed by logic outside the block as plain 3-bit values.
package dsd_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CY_READ   = 3'd0,
        CY_EWRITE = 3'd1,
        CY_RDWR   = 3'd2,
        CY_PAGE   = 3'd3,
        CY_ROWREF = 3'd4,
        CY_CBR    = 3'd5,
        CY_HIDDEN = 3'd6,
        CY_TEST   = 3'd7
    } cyc_e;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
        logic we_chg;
    } edge_t;
endpackage

// File: rtl/dsd_sampler.sv
`timescale 1ns/1ps
// Registers the strobes and the address once and derives edge pulses
// by comparing each sample with the one before it.
// Assumes: strobes are already synchronous to clk or slow enough that
// a single register stage is acceptable; idle strobe level is high.
module dsd_sampler #(
    parameter int AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               we_n,
    input  logic               oe_n,
    input  logic [AW-1:0]      addr,
    output logic               s_ras,
    output logic               s_cas,
    output logic               s_we,
    output logic               s_oe,
    output logic [AW-1:0]      addr_q,
    output dsd_pkg::edge_t     edg
);
    logic p_ras, p_cas, p_we;

    // Capture current strobe levels and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ras  <= 1'b1;
            s_cas  <= 1'b1;
            s_we   <= 1'b1;
            s_oe   <= 1'b1;
            addr_q <= '0;
        end else begin
            s_ras  <= ras_n;
            s_cas  <= cas_n;
            s_we   <= we_n;
            s_oe   <= oe_n;
            addr_q <= addr;
        end
    end

    // Keep the previous strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ras <= 1'b1;
            p_cas <= 1'b1;
            p_we  <= 1'b1;
        end else begin
            p_ras <= s_ras;
            p_cas <= s_cas;
            p_we  <= s_we;
        end
    end

    // Edge pulses, valid for the one cycle a new sample is current.
    always_comb begin
        edg.ras_fall = p_ras & ~s_ras;
        edg.ras_rise = ~p_ras & s_ras;
        edg.cas_fall = p_cas & ~s_cas;
        edg.cas_rise = ~p_cas & s_cas;
        edg.we_fall  = p_we & ~s_we;
        edg.we_chg   = p_we ^ s_we;
    end
endmodule

// File: rtl/dsd_refresh_ctr.sv
`timescale 1ns/1ps
// Internal refresh row counter; advances by one on each refresh that
// takes its row internally, wrapping at 2^AW.
// Assumes: adv is a single-cycle pulse.
module dsd_refresh_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] value
);
    localparam logic [AW-1:0] STEP = AW'(1);

    // Count refresh rows.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (adv) value <= value + STEP;
    end
endmodule

// File: rtl/dsd_classifier.sv
`timescale 1ns/1ps
// Cycle classifier: latches row and column, decides the class of each
// row and column cycle from strobe ordering, tracks the test flag and
// whether read data is available for the data pins.
// Assumes: edge pulses come from dsd_sampler; a column strobe pulsed
// during a refresh row period is not an access and is ignored.
module dsd_classifier #(
    parameter int AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_ras,
    input  logic               s_cas,
    input  logic               s_we,
    input  logic [AW-1:0]      addr_q,
    input  dsd_pkg::edge_t     edg,
    input  logic [AW-1:0]      ctr_val,
    output logic               adv,
    output logic               cyc_valid,
    output dsd_pkg::cyc_e      cyc_code,
    output logic [AW-1:0]      row_q,
    output logic [AW-1:0]      col_q,
    output logic               test_mode,
    output logic               proto_err,
    output logic               data_valid
);
    import dsd_pkg::*;

    logic  acc_pend;      // column latched, report not yet given
    cyc_e  acc_code;      // class of the pending access
    cyc_e  ref_code;      // class of the current refresh row period
    logic  is_ref;        // current row period is counter-addressed
    logic  col_seen;      // a column was latched in this row period
    logic  cas_from_acc;  // column strobe low since an access latch
    logic  cas_held;      // column strobe was already low at this sample
    logic  col_strobe;    // this sample opens an access column

    // Decode combinational qualifiers of the current sample.
    always_comb begin
        cas_held   = ~s_cas & ~edg.cas_fall;
        col_strobe = edg.cas_fall & ~s_ras & (edg.ras_fall | ~is_ref);
    end

    // Main sequencing of reports, latches and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv          <= 1'b0;
            cyc_valid    <= 1'b0;
            cyc_code     <= CY_READ;
            row_q        <= '0;
            col_q        <= '0;
            test_mode    <= 1'b0;
            proto_err    <= 1'b0;
            data_valid   <= 1'b0;
            acc_pend     <= 1'b0;
            acc_code     <= CY_READ;
            ref_code     <= CY_CBR;
            is_ref       <= 1'b0;
            col_seen     <= 1'b0;
            cas_from_acc <= 1'b0;
        end else begin
            cyc_valid <= 1'b0;
            proto_err <= 1'b0;
            adv       <= 1'b0;

            // Report: pending access first, then row-type classes.
            if (acc_pend && (edg.cas_rise || edg.ras_rise)) begin
                cyc_valid <= 1'b1;
                cyc_code  <= acc_code;
                acc_pend  <= 1'b0;
            end else if (edg.ras_rise && is_ref) begin
                cyc_valid <= 1'b1;
                cyc_code  <= ref_code;
            end else if (edg.ras_rise && !col_seen) begin
                cyc_valid <= 1'b1;
                cyc_code  <= CY_ROWREF;
                test_mode <= 1'b0;
            end
            if (edg.ras_rise) is_ref <= 1'b0;

            // Row open: refresh from the counter or row from the pins.
            if (edg.ras_fall) begin
                if (cas_held) begin
                    is_ref <= 1'b1;
                    row_q  <= ctr_val;
                    adv    <= 1'b1;
                    if (cas_from_acc) begin
                        ref_code <= CY_HIDDEN;
                    end else if (s_we) begin
                        ref_code  <= CY_CBR;
                        test_mode <= 1'b0;
                    end else begin
                        ref_code  <= CY_TEST;
                        test_mode <= 1'b1;
                    end
                    if (edg.we_chg) proto_err <= 1'b1;
                end else begin
                    is_ref   <= 1'b0;
                    col_seen <= 1'b0;
                    row_q    <= addr_q;
                    if (edg.cas_fall) proto_err <= 1'b1;
                end
            end

            // Column access latch and late-write upgrade.
            if (col_strobe) begin
                col_q        <= addr_q;
                acc_pend     <= 1'b1;
                col_seen     <= 1'b1;
                cas_from_acc <= 1'b1;
                data_valid   <= s_we;
                if (col_seen && !edg.ras_fall) acc_code <= CY_PAGE;
                else if (s_we)                  acc_code <= CY_READ;
                else                            acc_code <= CY_EWRITE;
            end else if (edg.we_fall && !s_cas && acc_pend && acc_code == CY_READ) begin
                acc_code <= CY_RDWR;
            end

            // Column strobe rise ends held data and hidden eligibility.
            if (edg.cas_rise) begin
                cas_from_acc <= 1'b0;
                data_valid   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dsd_dq_ctl.sv
`timescale 1ns/1ps
// Data-pin direction: memory drives only while both column strobe and
// output enable are low and read data is held.
// Assumes: data_valid is cleared by the classifier on a column rise.
module dsd_dq_ctl (
    input  logic s_cas,
    input  logic s_oe,
    input  logic data_valid,
    output logic dq_out_en
);
    // Combine the current levels with the held-data flag.
    always_comb dq_out_en = ~s_cas & ~s_oe & data_valid;
endmodule

// File: rtl/dram_strobe_decoder.sv
`timescale 1ns/1ps
// Top of the DRAM strobe cycle decoder: sampler, classifier, refresh
// counter and data-pin direction logic.
// Assumes: all inputs idle high between cycles; addr is stable in the
// sample where the matching strobe falls.
module dram_strobe_decoder #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    output logic          cyc_valid,
    output logic [2:0]    cyc_code,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q,
    output logic          test_mode,
    output logic          dq_out_en,
    output logic          proto_err
);
    import dsd_pkg::*;

    logic          s_ras, s_cas, s_we, s_oe;
    logic [AW-1:0] addr_q;
    edge_t         edg;
    logic [AW-1:0] ctr_val;
    logic          adv;
    logic          data_valid;
    cyc_e          code_e;

    dsd_sampler #(.AW(AW)) u_sampler (
        .clk(clk), .rst_n(rst_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we), .s_oe(s_oe),
        .addr_q(addr_q), .edg(edg)
    );

    dsd_refresh_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .adv(adv), .value(ctr_val)
    );

    dsd_classifier #(.AW(AW)) u_cls (
        .clk(clk), .rst_n(rst_n),
        .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we),
        .addr_q(addr_q), .edg(edg), .ctr_val(ctr_val),
        .adv(adv), .cyc_valid(cyc_valid), .cyc_code(code_e),
        .row_q(row_q), .col_q(col_q), .test_mode(test_mode),
        .proto_err(proto_err), .data_valid(data_valid)
    );

    dsd_dq_ctl u_dq (
        .s_cas(s_cas), .s_oe(s_oe), .data_valid(data_valid), .dq_out_en(dq_out_en)
    );

    // Present the class as a plain code.
    always_comb cyc_code = code_e;
endmodule

// File: rtl/dsd_checker.sv
`timescale 1ns/1ps
// Protocol checker for dram_strobe_decoder, attached by bind.
// Assumes: one register stage between pins and sampled levels, one more
// before the classifier's outputs.
module dsd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       cyc_valid,
    input logic [2:0] cyc_code,
    input logic       test_mode,
    input logic       dq_out_en,
    input logic       proto_err
);
    AST_DQ_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        dq_out_en |-> (!$past(cas_n) && !$past(oe_n))); // R10

    AST_TEST_NEEDS_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> (!$past(we_n, 2) && !$past(cas_n, 2) && !$past(ras_n, 2))); // R8

    AST_TEST_REPORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_code == 3'd7) |-> test_mode); // R8

    AST_CBR_CLEARS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_code == 3'd5) |-> !test_mode); // R7

    AST_ROWREF_CLEARS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_code == 3'd4) |-> !test_mode); // R6

    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err); // R11

    AST_REPORT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> ($past(ras_n, 2) || $past(cas_n, 2))); // R12
endmodule

bind dram_strobe_decoder dsd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
    .test_mode(test_mode), .dq_out_en(dq_out_en), .proto_err(proto_err)
);

// File: tb/dram_strobe_decoder_test.sv
`timescale 1ns/1ps
module dram_strobe_decoder_test;
    localparam int AW = 10;
    localparam int MOD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cyc_valid, test_mode, dq_out_en, proto_err;
    logic [2:0]    cyc_code;
    logic [AW-1:0] row_q, col_q;

    int checks = 0, errors = 0;
    int rep_cnt = 0, err_cnt = 0, last_code = -1;
    int exp_ctr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dram_strobe_decoder #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
        .row_q(row_q), .col_q(col_q), .test_mode(test_mode),
        .dq_out_en(dq_out_en), .proto_err(proto_err)
    );

    // Record report and error pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            rep_cnt++;
            last_code = int'(cyc_code);
        end
        if (rst_n && proto_err) err_cnt++;
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic drv(input logic r, input logic c, input logic w, input logic o,
                       input logic [AW-1:0] a);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle();
        drv(1, 1, 1, 1, '0);
    endtask

    // Column-before-row cycle with a chosen write-enable level.
    task automatic cbr(input logic w);
        drv(1, 0, w, 1, '0);
        drv(0, 0, w, 1, '0);
        drv(1, 0, w, 1, '0);
        drv(1, 1, 1, 1, '0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0, e0, row, col, exp_code, exp_dq;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 cyc_valid", cyc_valid, 0);
        chk("R1 test_mode", test_mode, 0);
        chk("R1 dq_out_en", dq_out_en, 0);
        chk("R1 proto_err", proto_err, 0);
        chk("R1 row_q", row_q, 0);
        chk("R1 col_q", col_q, 0);

        // Sweep write-enable placement x output enable: R2 R3 R4 R10 R12
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
                row = 97 * m + 13 * o + 5;
                col = MOD - 1 - row;
                exp_code = (m <= 1) ? 1 : ((m == 2) ? 2 : 0);
                exp_dq = (m >= 2 && o == 0) ? 1 : 0;
                drv(0, 1, 1, o[0], AW'(row));
                if (m == 0) drv(0, 1, 0, o[0], AW'(row));
                drv(0, 0, (m <= 1) ? 1'b0 : 1'b1, o[0], AW'(col));
                if (m == 2) drv(0, 0, 0, o[0], AW'(col));
                chk("R10 dq while column low", dq_out_en, exp_dq);
                r0 = rep_cnt;
                drv(0, 1, (m == 3) ? 1'b1 : 1'b0, o[0], '0);
                chk("R12 one report at column rise", rep_cnt, r0 + 1);
                chk((m <= 1) ? "R3 early write code" : ((m == 2) ? "R4 read-write code" : "R2 read code"),
                    last_code, exp_code);
                chk("R2 row latch", row_q, row);
                chk("R2 column latch", col_q, col);
                chk("R10 dq off after column rise", dq_out_en, 0);
                drv(1, 1, 1, 1, '0);
                chk("R12 no report at row rise", rep_cnt, r0 + 1);
            end
        end

        // R5 page mode: three columns in one row
        drv(0, 1, 1, 0, AW'(341));
        for (int k = 0; k < 3; k++) begin
            r0 = rep_cnt;
            drv(0, 0, 1, 0, AW'(200 + 7 * k));
            drv(0, 1, 1, 0, '0);
            chk("R5 page report count", rep_cnt, r0 + 1);
            chk("R5 page code", last_code, (k == 0) ? 0 : 3);
            chk("R5 page column", col_q, 200 + 7 * k);
        end
        drv(1, 1, 1, 1, '0);
        chk("R5 row kept", row_q, 341);

        // R9 hidden refresh with report moved to row rise (R12)
        drv(0, 1, 1, 0, AW'(77));
        drv(0, 0, 1, 0, AW'(88));
        r0 = rep_cnt;
        drv(1, 0, 1, 0, '0);
        chk("R12 access reported at row rise", rep_cnt, r0 + 1);
        chk("R12 access code", last_code, 0);
        chk("R9 dq held across row rise", dq_out_en, 1);
        drv(0, 0, 1, 0, '0);
        chk("R9 dq held in hidden refresh", dq_out_en, 1);
        chk("R9 hidden row from counter", row_q, exp_ctr);
        exp_ctr = (exp_ctr + 1) % MOD;
        drv(1, 0, 1, 0, '0);
        chk("R9 hidden code", last_code, 6);
        chk("R9 hidden report count", rep_cnt, r0 + 2);
        drv(1, 1, 1, 0, '0);
        chk("R9 no report at column rise", rep_cnt, r0 + 2);
        chk("R10 dq off", dq_out_en, 0);
        idle();

        // R8 test entry, kept through an access, cleared by R7 refresh
        cbr(1'b0);
        chk("R8 test code", last_code, 7);
        chk("R8 test set", test_mode, 1);
        chk("R8 test row from counter", row_q, exp_ctr);
        exp_ctr = (exp_ctr + 1) % MOD;
        drv(0, 1, 1, 1, AW'(9));
        drv(0, 0, 1, 1, AW'(10));
        drv(0, 1, 1, 1, '0);
        drv(1, 1, 1, 1, '0);
        chk("R8 access leaves test set", test_mode, 1);
        cbr(1'b1);
        chk("R7 refresh code", last_code, 5);
        chk("R7 refresh clears test", test_mode, 0);
        chk("R7 refresh row", row_q, exp_ctr);
        exp_ctr = (exp_ctr + 1) % MOD;

        // R6 row-only refresh sweep, first one after a test entry
        cbr(1'b0);
        exp_ctr = (exp_ctr + 1) % MOD;
        chk("R8 test set again", test_mode, 1);
        for (int k = 0; k < 4; k++) begin
            row = 255 * k + 3;
            r0 = rep_cnt;
            drv(0, 1, k[0], 1, AW'(row));
            drv(1, 1, 1, 1, '0);
            chk("R6 row-only report", rep_cnt, r0 + 1);
            chk("R6 row-only code", last_code, 4);
            chk("R6 row-only row", row_q, row);
            chk("R6 row-only clears test", test_mode, 0);
        end

        // R11 protocol errors
        chk("R11 no error so far", err_cnt, 0);
        e0 = err_cnt;
        drv(0, 0, 1, 1, AW'(21));
        chk("R11 simultaneous strobe fall", err_cnt, e0 + 1);
        drv(0, 1, 1, 1, '0);
        drv(1, 1, 1, 1, '0);
        e0 = err_cnt;
        drv(1, 0, 1, 1, '0);
        drv(0, 0, 0, 1, '0);
        chk("R11 write enable moved at refresh", err_cnt, e0 + 1);
        exp_ctr = (exp_ctr + 1) % MOD;
        drv(1, 0, 0, 1, '0);
        drv(1, 1, 1, 1, '0);
        chk("R8 entry despite error", last_code, 7);
        cbr(1'b1);
        exp_ctr = (exp_ctr + 1) % MOD;
        chk("R11 clean refresh no error", err_cnt, e0 + 1);

        // R7 counter sweep across the wrap point
        for (int i = 0; i < MOD + 3; i++) begin
            drv(1, 0, 1, 1, '0);
            drv(0, 0, 1, 1, '0);
            chk("R7 counter row", row_q, exp_ctr);
            exp_ctr = (exp_ctr + 1) % MOD;
            drv(1, 1, 1, 1, '0);
        end
        chk("R7 sweep last code", last_code, 5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule